// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous Memory with Sleep Hold

This block is a single-port synchronous word memory with registered inputs and a registered read path. An address sequencer upstream supplies an address and a select flag each cycle. A set of active-low write strobes decides whether a selected cycle reads or writes, and which of the four 8-bit lanes of the 32-bit word it writes. A global strobe writes the whole word. A lane-master strobe enables writes through the per-lane strobes.

Read data leaves through an output register, so it is valid one clock after the edge that captured the read. A drive-valid flag stands in for three-state control. The flag is raised only for selected reads. An active-low output enable and the sleep input both clear it without waiting for a clock.

While sleep is high, every register holds its value and no cycle is accepted, so the memory contents and the pipeline are kept. Depth is `2**ADDR_W` words. The default is 1024 words; `ADDR_W = 16` gives 65,536 words.

Top module: `sbw_sram`

## Requirements
- R1: After reset, `rdata_vld` is 0 and `rdata` is 0.
- R2: In a selected cycle with `all_wr_n` low, all four lanes are written from `wdata`, whatever `lane_master_n` and `lane_wr_n` hold.
- R3: In a selected cycle with `all_wr_n` high and `lane_master_n` low, lane i (bits 8i+7..8i) is written exactly when `lane_wr_n[i]` is 0. The other lanes keep their stored bytes.
- R4: A selected cycle is a read, and writes nothing, when `all_wr_n` is high and either `lane_master_n` is high or all four `lane_wr_n` bits are 1.
- R5: A read captured on clock edge k drives `rdata_vld` = 1 and the word on `rdata` after edge k+1, and not after edge k.
- R6: A write captured on edge k followed by a read of the same address captured on edge k+1 returns the newly written word.
- R7: A cycle with `sel` low writes nothing. If it is captured on edge k, `rdata_vld` is 0 after edge k+1.
- R8: A write captured on edge k leaves `rdata_vld` at 0 after edge k+1.
- R9: While `out_en_n` is high, `rdata_vld` and `rdata` are 0 with no clock edge needed. Lowering it again restores the registered word.
- R10: While `sleep` is high, `rdata_vld` is 0 and cycles presented are ignored, including writes. When `sleep` returns low, the output register and memory hold what they held before sleep.
- R11: Reads captured on consecutive edges return one word per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Cycle select from the address sequencer |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| all_wr_n | input | 1 | Active-low whole-word write |
| lane_master_n | input | 1 | Active-low enable for per-lane writes |
| lane_wr_n | input | 4 | Active-low per-lane write strobes |
| out_en_n | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Asynchronous hold: ignore cycles, keep state |
| rdata | output | 32 | Read data, 0 when not driven |
| rdata_vld | output | 1 | Read data is being driven |

## Verification
Writes take effect on their capture edge, so a read captured on the very next edge is expected to return the new word two edges after the write. A read result is due after the edge following its capture edge. The bench first confirms that the output has not yet changed after the capture edge, then samples it at the falling edge after edge k+1. Deselect and write cycles are checked as a dropped `rdata_vld` at that same point. The effects of `out_en_n` and `sleep` are checked within a single low clock phase, with no edge between stimulus and sample.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // per-lane write decision for one lane, active-high result
    function automatic logic lane_writes(input logic all_n,
                                         input logic master_n,
                                         input logic lane_n);
        return (!all_n) || (!master_n && !lane_n);
    endfunction

endpackage

// File: rtl/sbw_lane_decode.sv
module sbw_lane_decode
    import sbw_pkg::*;
(
    input  logic       sel,
    input  logic       sleep,
    input  logic       all_wr_n,
    input  logic       lane_master_n,
    input  lane_mask_t lane_wr_n,
    output lane_mask_t lane_we,
    output op_e        op
);
    logic accept;
    assign accept = sel && !sleep;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = accept && lane_writes(all_wr_n, lane_master_n, lane_wr_n[i]);
    end

    always_comb begin
        if (!accept)       op = OP_IDLE;
        else if (|lane_we) op = OP_WRITE;
        else               op = OP_READ;
    end
endmodule

// File: rtl/sbw_mem_array.sv
module sbw_mem_array
    import sbw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  lane_mask_t        lane_we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rword
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[l]) store[waddr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rword[l*LANE_W +: LANE_W] = store[raddr];
    end
endmodule

// File: rtl/sbw_out_stage.sv
module sbw_out_stage
    import sbw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  op_e   op_q,
    input  word_t rword,
    input  logic  out_en_n,
    output word_t rdata,
    output logic  rdata_vld
);
    word_t dout_q;
    logic  drive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q  <= '0;
            drive_q <= 1'b0;
        end else if (!hold) begin
            drive_q <= (op_q == OP_READ);
            if (op_q == OP_READ) dout_q <= rword;
        end
    end

    logic show;
    assign show      = drive_q && !out_en_n && !hold;
    assign rdata_vld = show;
    assign rdata     = show ? dout_q : '0;

    // R5: a captured read drives the output after the next edge
    a_r5_read_drives: assert property (@(posedge clk) disable iff (rst)
        (!hold && op_q == OP_READ) |=> drive_q);

    // R7: a deselected cycle stops the drive after the next edge
    a_r7_idle_releases: assert property (@(posedge clk) disable iff (rst)
        (!hold && op_q == OP_IDLE) |=> !drive_q);

    // R8: a write never drives the output
    a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (!hold && op_q == OP_WRITE) |=> !drive_q);

    // R10: sleep keeps the output register
    a_r10_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(dout_q) && $stable(drive_q)));
endmodule

// File: rtl/sbw_sram.sv
module sbw_sram
    import sbw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              all_wr_n,
    input  logic              lane_master_n,
    input  logic [3:0]        lane_wr_n,
    input  logic              out_en_n,
    input  logic              sleep,
    output logic [31:0]       rdata,
    output logic              rdata_vld
);
    lane_mask_t        lane_we;
    op_e               op_d;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    word_t             rword;

    sbw_lane_decode u_dec (
        .sel           (sel),
        .sleep         (sleep),
        .all_wr_n      (all_wr_n),
        .lane_master_n (lane_master_n),
        .lane_wr_n     (lane_wr_n),
        .lane_we       (lane_we),
        .op            (op_d)
    );

    sbw_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (addr),
        .wdata   (wdata),
        .raddr   (addr_q),
        .rword   (rword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
        end else if (!sleep) begin
            op_q   <= op_d;
            addr_q <= addr;
        end
    end

    sbw_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .hold      (sleep),
        .op_q      (op_q),
        .rword     (rword),
        .out_en_n  (out_en_n),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    // R10: no cycle is captured while sleeping
    a_r10_sleep_no_capture: assert property (@(posedge clk) disable iff (rst)
        sleep |=> $stable(op_q));
endmodule

// File: tb/sbw_sram_tb.sv
module sbw_sram_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic          all_wr_n, lane_master_n;
    logic [3:0]    lane_wr_n;
    logic          out_en_n, sleep;
    logic [31:0]   rdata;
    logic          rdata_vld;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbw_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .sel(sel), .addr(addr), .wdata(wdata),
        .all_wr_n(all_wr_n), .lane_master_n(lane_master_n), .lane_wr_n(lane_wr_n),
        .out_en_n(out_en_n), .sleep(sleep), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // set inputs in the low phase
    task automatic drive(input logic s, input logic [AW-1:0] a, input logic [31:0] d,
                         input logic g, input logic m, input logic [3:0] l);
        sel = s; addr = a; wdata = d; all_wr_n = g; lane_master_n = m; lane_wr_n = l;
    endtask

    task automatic idle_in();
        drive(1'b0, '0, 32'h0, 1'b1, 1'b1, 4'hF);
    endtask

    // one cycle: drive at negedge, capture at posedge, return at next negedge
    task automatic step(input logic s, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic g, input logic m, input logic [3:0] l);
        drive(s, a, d, g, m, l);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_full(input logic [AW-1:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 1'b0, 4'h0);
        idle_in();
    endtask

    // read: captured on edge k, checked after edge k+1
    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        step(1'b1, a, 32'h0, 1'b1, 1'b1, 4'hF);
        idle_in();
        @(posedge clk);
        @(negedge clk);
        chk({req, " vld"}, {31'b0, rdata_vld}, 32'd1);
        chk({req, " data"}, rdata, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1; out_en_n = 1'b0; sleep = 1'b0; idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R1 vld", {31'b0, rdata_vld}, 32'd0);
        chk("R1 data", rdata, 32'h0);
    endtask

    task automatic t_global_write();
        // master and lane strobes inactive, global strobe alone writes all lanes
        step(1'b1, 10'h010, 32'hCAFE_F00D, 1'b0, 1'b1, 4'hF); idle_in();
        rd_check("R2", 10'h010, 32'hCAFE_F00D);
        // global strobe with lanes partly off still writes all
        step(1'b1, 10'h010, 32'h0102_0304, 1'b0, 1'b0, 4'b1110); idle_in();
        rd_check("R2 override", 10'h010, 32'h0102_0304);
    endtask

    task automatic t_lane_write();
        wr_full(10'h020, 32'h1122_3344);
        step(1'b1, 10'h020, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1010); idle_in();
        rd_check("R3 lanes 0,2", 10'h020, 32'h11BB_33DD);
        step(1'b1, 10'h020, 32'hEE00_0000, 1'b1, 1'b0, 4'b0111); idle_in();
        rd_check("R3 lane 3", 10'h020, 32'hEEBB_33DD);
    endtask

    task automatic t_read_forms();
        wr_full(10'h030, 32'h5555_AAAA);
        // master low, all lanes high: read
        step(1'b1, 10'h030, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'hF); idle_in();
        @(posedge clk); @(negedge clk);
        chk("R4 master-low read vld", {31'b0, rdata_vld}, 32'd1);
        chk("R4 master-low read data", rdata, 32'h5555_AAAA);
        // master high, lanes low: read
        step(1'b1, 10'h030, 32'h0, 1'b1, 1'b1, 4'h0); idle_in();
        @(posedge clk); @(negedge clk);
        chk("R4 master-high read data", rdata, 32'h5555_AAAA);
        rd_check("R4 unchanged", 10'h030, 32'h5555_AAAA);
    endtask

    task automatic t_latency();
        wr_full(10'h040, 32'h1357_9BDF);
        repeat (2) begin @(posedge clk); @(negedge clk); end
        step(1'b1, 10'h040, 32'h0, 1'b1, 1'b1, 4'hF); idle_in();
        chk("R5 not after k", {31'b0, rdata_vld}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R5 after k+1 vld", {31'b0, rdata_vld}, 32'd1);
        chk("R5 after k+1 data", rdata, 32'h1357_9BDF);
    endtask

    task automatic t_write_then_read();
        wr_full(10'h050, 32'h0000_0001);
        step(1'b1, 10'h050, 32'hDEAD_BEEF, 1'b0, 1'b0, 4'h0);
        rd_check("R6", 10'h050, 32'hDEAD_BEEF);
    endtask

    task automatic t_deselect();
        wr_full(10'h060, 32'h6060_6060);
        step(1'b1, 10'h060, 32'h0, 1'b1, 1'b1, 4'hF);
        // deselected cycle with every write strobe low, captured at k+1
        step(1'b0, 10'h060, 32'hFFFF_0000, 1'b0, 1'b0, 4'h0);
        chk("R7 read still out", {31'b0, rdata_vld}, 32'd1);
        idle_in();
        @(posedge clk); @(negedge clk);
        chk("R7 released", {31'b0, rdata_vld}, 32'd0);
        rd_check("R7 no write", 10'h060, 32'h6060_6060);
    endtask

    task automatic t_write_quiet();
        wr_full(10'h070, 32'h7070_7070);
        step(1'b1, 10'h070, 32'h0, 1'b1, 1'b1, 4'hF);
        step(1'b1, 10'h071, 32'h7171_7171, 1'b0, 1'b1, 4'hF);
        chk("R8 prior read out", rdata, 32'h7070_7070);
        idle_in();
        @(posedge clk); @(negedge clk);
        chk("R8 write not driven", {31'b0, rdata_vld}, 32'd0);
    endtask

    task automatic t_out_enable();
        wr_full(10'h080, 32'h8080_0808);
        step(1'b1, 10'h080, 32'h0, 1'b1, 1'b1, 4'hF); idle_in();
        @(posedge clk); @(negedge clk);
        out_en_n = 1'b1; #1;
        chk("R9 off vld", {31'b0, rdata_vld}, 32'd0);
        chk("R9 off data", rdata, 32'h0);
        out_en_n = 1'b0; #1;
        chk("R9 back on", rdata, 32'h8080_0808);
    endtask

    task automatic t_sleep();
        wr_full(10'h090, 32'h9090_0909);
        step(1'b1, 10'h090, 32'h0, 1'b1, 1'b1, 4'hF);
        sleep = 1'b1;
        drive(1'b1, 10'h090, 32'h0BAD_0BAD, 1'b0, 1'b0, 4'h0);
        @(posedge clk); #1;
        chk("R10 sleep quiet", {31'b0, rdata_vld}, 32'd0);
        @(negedge clk);
        drive(1'b1, 10'h091, 32'h0, 1'b1, 1'b1, 4'hF);
        @(posedge clk); @(negedge clk);
        chk("R10 still quiet", {31'b0, rdata_vld}, 32'd0);
        idle_in(); sleep = 1'b0; #1;
        // pending read in the pipe resumes after wake
        @(posedge clk); @(negedge clk);
        chk("R10 resume vld", {31'b0, rdata_vld}, 32'd1);
        chk("R10 resume data", rdata, 32'h9090_0909);
        rd_check("R10 write ignored", 10'h090, 32'h9090_0909);
    endtask

    task automatic t_stream();
        wr_full(10'h0A0, 32'hA0A0_0001);
        wr_full(10'h0A1, 32'hA1A1_0002);
        wr_full(10'h0A2, 32'hA2A2_0003);
        step(1'b1, 10'h0A0, 32'h0, 1'b1, 1'b1, 4'hF);
        step(1'b1, 10'h0A1, 32'h0, 1'b1, 1'b1, 4'hF);
        chk("R11 word 0", rdata, 32'hA0A0_0001);
        step(1'b1, 10'h0A2, 32'h0, 1'b1, 1'b1, 4'hF);
        chk("R11 word 1", rdata, 32'hA1A1_0002);
        idle_in();
        @(posedge clk); @(negedge clk);
        chk("R11 word 2", rdata, 32'hA2A2_0003);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_global_write();
        t_lane_write();
        t_read_forms();
        t_latency();
        t_write_then_read();
        t_deselect();
        t_write_quiet();
        t_out_enable();
        t_sleep();
        t_stream();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule